// File: doc/BRIEF.md
# Battery-Backed SRAM Window Decoder

This block sits between a host memory bus and a 2 MB battery-backed SRAM. It decides, within the same cycle, whether a bus memory cycle falls inside the SRAM's window. When it does, it raises a hit flag for the bus data buffers, drives the SRAM chip-select while a read or write strobe is active, and forms the 21-bit SRAM address.

Two mappings are available, and an 8-bit mode value picks between them. The first is a paged mode: a 32 KB window sits at one of eight base addresses, and a 6-bit page number supplies the upper SRAM address bits. A further mode bit chooses between two tables of eight bases. A short table for 20-bit hosts compares only a few address bits. A long table for 32-bit hosts compares every bit from 15 upward. The second is a linear mode, which maps the whole 2 MB flat at one of two bases.

A power-good input blocks every SRAM access while it is low. The block also drives two status LEDs from the power-good and battery-warning inputs, and resynchronises both onto the clock first.

Top module: `nvw_decoder`

## Requirements
- R1: With mode bits 7 (linear) and 6 (paged) both clear, no address produces a hit and sram_cs_o stays low.
- R2: With mode bit 7 set, a hit occurs for addresses in a 2 MB region based at 0x2A80_0000 when mode bit 0 is 0, or at 0x2AA0_0000 when it is 1. Mode bits 6, 2 and 1 have no effect in this mode.
- R3: In linear mode, sram_addr_o equals bus address bits 20..0.
- R4: In paged mode, sram_addr_o is page_i bits 5..0 followed by bus address bits 14..0. page_i bits 7..6 are ignored.
- R5: In paged mode with mode bit 3 clear, only bus address bits 19..15 are compared. Mode bits 2..0 (values 0..7) place the 32 KB window at 0xA0000, 0xA8000, 0xB0000, 0xB8000, 0xC0000, 0xC8000, 0xD0000 or 0xD8000. Address bits above 19 are ignored.
- R6: In paged mode with mode bit 3 set, every address bit from 15 upward must match. Values 0..3 of mode bits 2..0 place the window at 0x1180_0000 plus value×0x1_0000. Values 4..7 place it at 0x11B0_0000 plus (value−4)×0x1_0000. Each window is 32 KB.
- R7: While pwr_good_i is low, hit_o and sram_cs_o are low, whatever the address or mode.
- R8: sram_cs_o is high only when hit_o is high and mem_rd_i or mem_wr_i is high.
- R9: led_green_o follows pwr_good_i and led_red_o follows batt_warn_i, each through two clock stages. Both LEDs are low during reset.
- R10: Linear mode takes priority over paged mode. Mode value 0x46 gives a paged window at 0xD0000..0xD7FFF. Mode value 0x80 gives a linear region at 0x2A80_0000..0x2A9F_FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for LED synchronisers |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | ADDR_W (32) | Bus memory address |
| mem_rd_i | input | 1 | Memory read strobe, active high |
| mem_wr_i | input | 1 | Memory write strobe, active high |
| page_i | input | 8 | Page register value |
| mode_i | input | 8 | Mode register value |
| pwr_good_i | input | 1 | Supply-good indication |
| batt_warn_i | input | 1 | Battery low warning |
| sram_cs_o | output | 1 | SRAM chip-select, active high |
| sram_addr_o | output | 21 | SRAM word address |
| hit_o | output | 1 | Address inside enabled window |
| led_red_o | output | 1 | Battery warning LED |
| led_green_o | output | 1 | Supply-good LED |

## Verification
Two functions can act in the same cycle. The window decode may match a cycle while the power-fail gate must suppress that same match.

The stimulus drops pwr_good_i randomly. It also drops it on directed cycles whose address sits exactly on a window base or its last byte, and drives a strobe on those cycles. The bench judges these cycles by requiring both hit_o and sram_cs_o low. It then checks that the same address hits once power returns, which shows the suppression came from the gate and not from a decode miss.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  localparam int SRAM_AW  = 21;
  localparam int PAGE_W   = 6;
  localparam int WIN_LSB  = 15;
  localparam int SHORT_HI = 19;

  localparam int M_LINEAR = 7;
  localparam int M_PAGED  = 6;
  localparam int M_DECODE = 3;

  typedef struct packed {
    logic       linear;
    logic       paged;
    logic       wide;
    logic [2:0] sel;
  } map_cfg_t;

  function automatic logic [31:0] lin_base(input logic sel0);
    return 32'h2A80_0000 | ({31'd0, sel0} << SRAM_AW);
  endfunction

  function automatic logic [31:0] short_base(input logic [2:0] sel);
    return 32'h000A_0000 + ({29'd0, sel} << WIN_LSB);
  endfunction

  function automatic logic [31:0] long_base(input logic [2:0] sel);
    return 32'h1180_0000 | (sel[2] ? 32'h0030_0000 : 32'h0) | ({30'd0, sel[1:0]} << 16);
  endfunction
endpackage

// File: rtl/nvw_base_sel.sv
module nvw_base_sel
  import nvw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  map_cfg_t          cfg_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] mask_o,
  output logic              en_o
);
  localparam logic [ADDR_W-1:0] ONES     = '1;
  localparam logic [ADDR_W-1:0] MASK_LIN = ONES << SRAM_AW;
  localparam logic [ADDR_W-1:0] MASK_WID = ONES << WIN_LSB;
  localparam logic [ADDR_W-1:0] MASK_SHT = MASK_WID & ~(ONES << (SHORT_HI + 1));

  always_comb begin
    en_o = cfg_i.linear | cfg_i.paged;
    if (cfg_i.linear) begin
      base_o = ADDR_W'(lin_base(cfg_i.sel[0]));
      mask_o = MASK_LIN;
    end else if (cfg_i.wide) begin
      base_o = ADDR_W'(long_base(cfg_i.sel));
      mask_o = MASK_WID;
    end else begin
      base_o = ADDR_W'(short_base(cfg_i.sel));
      mask_o = MASK_SHT;
    end
  end
endmodule

// File: rtl/nvw_win_match.sv
module nvw_win_match #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] mask_i,
  input  logic              en_i,
  output logic              match_o
);
  assign match_o = en_i & ~|((addr_i ^ base_i) & mask_i);
endmodule

// File: rtl/nvw_sram_addr.sv
module nvw_sram_addr
  import nvw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [PAGE_W-1:0]  page_i,
  input  logic               linear_i,
  output logic [SRAM_AW-1:0] sram_addr_o
);
  always_comb begin
    if (linear_i) sram_addr_o = addr_i[SRAM_AW-1:0];
    else          sram_addr_o = {page_i, addr_i[WIN_LSB-1:0]};
  end
endmodule

// File: rtl/nvw_led_sync.sv
module nvw_led_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[g] <= 1'b0;
        q_o[g]    <= 1'b0;
      end else begin
        meta_q[g] <= d_i[g];
        q_o[g]    <= meta_q[g];
      end
    end
  end
endmodule

// File: rtl/nvw_decoder.sv
module nvw_decoder
  import nvw_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               mem_rd_i,
  input  logic               mem_wr_i,
  input  logic [7:0]         page_i,
  input  logic [7:0]         mode_i,
  input  logic               pwr_good_i,
  input  logic               batt_warn_i,
  output logic               sram_cs_o,
  output logic [SRAM_AW-1:0] sram_addr_o,
  output logic               hit_o,
  output logic               led_red_o,
  output logic               led_green_o
);
  map_cfg_t          cfg;
  logic [ADDR_W-1:0] base, mask;
  logic              win_en, win_match;
  logic [1:0]        led_q;
  logic              unused_bits;

  assign cfg.linear = mode_i[M_LINEAR];
  assign cfg.paged  = mode_i[M_PAGED];
  assign cfg.wide   = mode_i[M_DECODE];
  assign cfg.sel    = mode_i[2:0];
  assign unused_bits = ^{page_i[7:PAGE_W], mode_i[5:4]};

  nvw_base_sel #(.ADDR_W(ADDR_W)) u_base (
    .cfg_i(cfg), .base_o(base), .mask_o(mask), .en_o(win_en)
  );

  nvw_win_match #(.ADDR_W(ADDR_W)) u_match (
    .addr_i(bus_addr_i), .base_i(base), .mask_i(mask),
    .en_i(win_en), .match_o(win_match)
  );

  nvw_sram_addr #(.ADDR_W(ADDR_W)) u_addr (
    .addr_i(bus_addr_i), .page_i(page_i[PAGE_W-1:0]),
    .linear_i(cfg.linear), .sram_addr_o(sram_addr_o)
  );

  // power-fail gate uses the raw input: no sync delay on inhibit
  assign hit_o     = win_match & pwr_good_i;
  assign sram_cs_o = hit_o & (mem_rd_i | mem_wr_i);

  nvw_led_sync #(.WIDTH(2)) u_led (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .d_i({batt_warn_i, pwr_good_i}), .q_o(led_q)
  );
  assign led_green_o = led_q[0];
  assign led_red_o   = led_q[1];

  // cycles since reset, saturating, for the LED latency check
  logic [1:0] chk_age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                chk_age_q <= 2'd0;
    else if (chk_age_q != 2'd2) chk_age_q <= chk_age_q + 2'd1;
  end

  p_mode_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[M_LINEAR] && !mode_i[M_PAGED]) |-> (!hit_o && !sram_cs_o));
  p_lin_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && mode_i[M_LINEAR]) |-> sram_addr_o == bus_addr_i[SRAM_AW-1:0]);
  p_page_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !mode_i[M_LINEAR]) |-> sram_addr_o[SRAM_AW-1:WIN_LSB] == page_i[PAGE_W-1:0]);
  p_pwr_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> (!hit_o && !sram_cs_o));
  p_cs_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_cs_o |-> (hit_o && (mem_rd_i || mem_wr_i)));
  p_led_green_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_age_q == 2'd2) |-> led_green_o == $past(pwr_good_i, 2));
  p_led_red_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_age_q == 2'd2) |-> led_red_o == $past(batt_warn_i, 2));
endmodule

// File: tb/nvw_decoder_test.sv
module nvw_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] addr = '0;
  logic        rd = 0, wr = 0, pg = 1, bw = 0;
  logic [7:0]  page = '0, mode = '0;
  logic        cs, hit, led_r, led_g;
  logic [20:0] saddr;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  nvw_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .mem_rd_i(rd), .mem_wr_i(wr),
    .page_i(page), .mode_i(mode), .pwr_good_i(pg), .batt_warn_i(bw),
    .sram_cs_o(cs), .sram_addr_o(saddr), .hit_o(hit),
    .led_red_o(led_r), .led_green_o(led_g)
  );

  function automatic logic [31:0] tab_base(input logic [7:0] m);
    logic [31:0] b;
    if (m[7]) b = m[0] ? 32'h2AA0_0000 : 32'h2A80_0000;
    else if (m[3])
      case (m[2:0])
        3'd0: b = 32'h1180_0000; 3'd1: b = 32'h1181_0000;
        3'd2: b = 32'h1182_0000; 3'd3: b = 32'h1183_0000;
        3'd4: b = 32'h11B0_0000; 3'd5: b = 32'h11B1_0000;
        3'd6: b = 32'h11B2_0000; default: b = 32'h11B3_0000;
      endcase
    else
      case (m[2:0])
        3'd0: b = 32'hA0000; 3'd1: b = 32'hA8000; 3'd2: b = 32'hB0000;
        3'd3: b = 32'hB8000; 3'd4: b = 32'hC0000; 3'd5: b = 32'hC8000;
        3'd6: b = 32'hD0000; default: b = 32'hD8000;
      endcase
    return b;
  endfunction

  function automatic logic exp_win(input logic [31:0] a, input logic [7:0] m);
    logic [31:0] b;
    b = tab_base(m);
    if (m[7]) return (a >= b) && (a <= b + 32'h1F_FFFF);
    if (!m[6]) return 1'b0;
    if (m[3]) return (a >= b) && (a < b + 32'h8000);
    return ({12'd0, a[19:0]} >= b) && ({12'd0, a[19:0]} < b + 32'h8000);
  endfunction

  function automatic logic [20:0] exp_saddr(input logic [31:0] a, input logic [7:0] m,
                                            input logic [7:0] p);
    return m[7] ? a[20:0] : {p[5:0], a[14:0]};
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [7:0] m, input logic [7:0] p,
                       input logic r, input logic w, input logic g);
    @(negedge clk);
    addr = a; mode = m; page = p; rd = r; wr = w; pg = g;
    #2;
  endtask

  task automatic check_all(input string req);
    logic eh, ec;
    eh = exp_win(addr, mode) && pg;
    ec = eh && (rd || wr);
    chk(hit == eh, req, {31'd0, hit}, {31'd0, eh});
    chk(cs == ec, req, {31'd0, cs}, {31'd0, ec});
    if (eh) chk(saddr == exp_saddr(addr, mode, page), req, {11'd0, saddr},
                {11'd0, exp_saddr(addr, mode, page)});
  endtask

  task automatic expect_hit(input logic [31:0] a, input logic [7:0] m, input logic e,
                            input string req);
    drive(a, m, 8'h05, 1'b1, 1'b0, 1'b1);
    chk(hit == e, req, {31'd0, hit}, {31'd0, e});
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    #5;
    chk(led_r == 0 && led_g == 0, "R9 reset", {30'd0, led_r, led_g}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: mode zero
    expect_hit(32'hD0000, 8'h00, 1'b0, "R1");
    expect_hit(32'h2A80_0000, 8'h30, 1'b0, "R1");
    drive(32'hD0000, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1);
    chk(cs == 0, "R1 cs", {31'd0, cs}, 32'd0);
    // R10 / R5 paged short
    expect_hit(32'hD0000, 8'h46, 1'b1, "R10 low");
    expect_hit(32'hD7FFF, 8'h46, 1'b1, "R10 top");
    expect_hit(32'hD8000, 8'h46, 1'b0, "R10 above");
    expect_hit(32'hCFFFF, 8'h46, 1'b0, "R10 below");
    expect_hit(32'h7F5D_1234, 8'h46, 1'b1, "R5 upper ignored");
    expect_hit(32'hA4000, 8'h40, 1'b1, "R5 sel0");
    expect_hit(32'hDC000, 8'h47, 1'b1, "R5 sel7");
    // R6 paged wide
    expect_hit(32'h11B0_0000, 8'h4C, 1'b1, "R6 sel4");
    expect_hit(32'h11B0_8000, 8'h4C, 1'b0, "R6 32K limit");
    expect_hit(32'h11B1_7FFF, 8'h4D, 1'b1, "R6 sel5");
    expect_hit(32'h1183_0010, 8'h4B, 1'b1, "R6 sel3");
    expect_hit(32'h0183_0010, 8'h4B, 1'b0, "R6 high bits");
    expect_hit(32'h000D_0000, 8'h4E, 1'b0, "R6 short base");
    // R10 / R2 linear
    expect_hit(32'h2A80_0000, 8'h80, 1'b1, "R10 lin low");
    expect_hit(32'h2A9F_FFFF, 8'h80, 1'b1, "R10 lin top");
    expect_hit(32'h2AA0_0000, 8'h80, 1'b0, "R10 lin above");
    expect_hit(32'h2AA0_0000, 8'hC7, 1'b1, "R2 sel0=1 paged ignored");
    expect_hit(32'h000D_8000, 8'hC7, 1'b0, "R2 paged table unused");
    expect_hit(32'h2ABF_FFFF, 8'h8F, 1'b1, "R2 upper sel ignored");
    // R3 linear address
    drive(32'h2A9A_BCDE, 8'h80, 8'h3F, 1'b0, 1'b1, 1'b1);
    chk(saddr == 21'h1A_BCDE, "R3", {11'd0, saddr}, 32'h1A_BCDE);
    // R4 page composition, upper page bits ignored
    drive(32'hD1234, 8'h46, 8'hFF, 1'b1, 1'b0, 1'b1);
    chk(saddr == {6'h3F, 15'h1234}, "R4", {11'd0, saddr}, {11'd0, 6'h3F, 15'h1234});
    drive(32'hD5555, 8'h46, 8'h81, 1'b1, 1'b0, 1'b1);
    chk(saddr == {6'h01, 15'h5555}, "R4 b7", {11'd0, saddr}, {11'd0, 6'h01, 15'h5555});
    // R8 strobes
    drive(32'hD0000, 8'h46, 8'h00, 1'b0, 1'b0, 1'b1);
    chk(hit == 1 && cs == 0, "R8 no strobe", {30'd0, hit, cs}, 32'h2);
    drive(32'hD0000, 8'h46, 8'h00, 1'b0, 1'b1, 1'b1);
    chk(cs == 1, "R8 write", {31'd0, cs}, 32'd1);
    // R7 power fail on window edges, then recovery
    drive(32'hD7FFF, 8'h46, 8'h00, 1'b1, 1'b1, 1'b0);
    chk(hit == 0 && cs == 0, "R7 paged", {30'd0, hit, cs}, 32'd0);
    drive(32'h2A80_0000, 8'h80, 8'h00, 1'b1, 1'b0, 1'b0);
    chk(hit == 0 && cs == 0, "R7 linear", {30'd0, hit, cs}, 32'd0);
    drive(32'h2A80_0000, 8'h80, 8'h00, 1'b1, 1'b0, 1'b1);
    chk(hit == 1 && cs == 1, "R7 recover", {30'd0, hit, cs}, 32'h3);

    // R9 LED latency
    drive(32'h0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    @(negedge clk); bw = 1'b1; pg = 1'b0;
    @(negedge clk);
    chk(led_r == 0 && led_g == 1, "R9 one stage", {30'd0, led_r, led_g}, 32'h1);
    @(negedge clk);
    chk(led_r == 1 && led_g == 0, "R9 two stages", {30'd0, led_r, led_g}, 32'h2);
    @(negedge clk); bw = 1'b0; pg = 1'b1;
    repeat (2) @(negedge clk);
    chk(led_r == 0 && led_g == 1, "R9 back", {30'd0, led_r, led_g}, 32'h1);

    // random mix: R2 R3 R4 R5 R6 R7 R8
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  m;
      logic [31:0] a;
      m = 8'($urandom);
      if ($urandom % 4 != 0) m[6] = 1'b1;
      if ($urandom % 3 == 0) m[7] = 1'b1;
      case ($urandom % 4)
        0: a = $urandom;
        1: a = tab_base(m) + ($urandom % 32'h1_0000);
        2: a = tab_base(m) - 32'd1 + ($urandom % 2) * 32'h8001;
        default: a = {$urandom % 32'h1000, tab_base(m)[19:0] + 20'($urandom % 32'h9000)};
      endcase
      drive(a, m, 8'($urandom), 1'($urandom), 1'($urandom), ($urandom % 5) != 0);
      check_all("R2-R8 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule